// File: doc/BRIEF.md
# Debounced Button Rising-Edge Pulser

This block turns a raw, asynchronous, bouncing push-button level into one clean pulse, a single clock wide, for each real press. Everything runs on one system clock. The button never clocks anything. It only decides what the registers load. The raw level first passes through a short flip-flop synchronizer. The synchronized level then shifts into a history register, one sample per clock.

A press counts only when the whole history matches one fixed shape. The oldest samples must be low and every newer sample must be high. With the default sizes the history is 16 samples: two settled lows followed by fourteen sustained highs. Contact bounce, short glitches and presses without a settled low before them never form that shape, so they give no pulse. A button held high gives exactly one pulse, because the shape matches only at the one instant it completes. The pulse comes from a register, so it appears one clock after the match.

Top module: `btn_press_pulser`

## Requirements
- R1: The raw button reaches the history only after two flip-flop stages clocked by the system clock. A level that is present at clock edge k is the synchronized level after edge k+1.
- R2: While `rst` is high at a clock edge, both synchronizer stages, the history and `press_pulse` are cleared to 0. `press_pulse` reads 0 throughout reset.
- R3: `press_pulse` rises a fixed time after a valid press. If `btn_raw` goes high just before edge c+1 and stays high, after at least two low synchronized samples, then `press_pulse` is 1 in the cycle after edge c+17. The 17 clocks are 2 for synchronizing, 14 for filling the pattern and 1 for the output register.
- R4: `press_pulse` is exactly one clock wide.
- R5: A button held high for any length of time after a valid press gives no further pulse.
- R6: A bouncing press gives exactly one pulse. The pulse belongs to the final high run that lasts at least 14 samples and has at least two low samples before it.
- R7: A high run shorter than 14 synchronized samples gives no pulse. A run of exactly 14 samples, with two lows before it, gives one pulse.
- R8: A high run with only one low sample before it gives no pulse, however long it lasts.
- R9: The history shifts every clock. The newest synchronized sample enters at bit 0, each older sample moves one bit up, and the oldest sample leaves from the top bit. The pattern that fires is 16'b0011111111111111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every register uses its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| btn_raw | input | 1 | Raw, asynchronous push-button level, high when pressed |
| press_pulse | output | 1 | One-clock pulse for each accepted press |

## Verification
The hardest cases to reach are the ones at the edge of the pattern. These are a high run of exactly 14 samples against one of 13, and a long high run with one low sample before it against one with two. The stimulus drives `btn_raw` at falling clock edges, so each sample count is exact to the clock. For every accepted rise, the bench computes the one cycle in which the pulse must appear. A monitor compares each observed pulse with that queue. Any pulse nobody predicted, and any predicted pulse that never comes, is an error.

// File: rtl/btn_pulser_pkg.sv
package btn_pulser_pkg;

  localparam int MAX_HIST = 64;

  // Acceptance shape: the LOW_LEN oldest samples are 0, all newer samples are 1.
  function automatic logic [MAX_HIST-1:0] settle_pattern(input int hist_len, input int low_len);
    logic [MAX_HIST-1:0] p;
    p = '0;
    for (int i = 0; i < MAX_HIST; i++) begin
      if (i < hist_len - low_len) p[i] = 1'b1;
    end
    return p;
  endfunction

  // Clocks from a stable raw high to the visible pulse.
  function automatic int press_latency(input int sync_stages, input int hist_len, input int low_len);
    return sync_stages + (hist_len - low_len) + 1;
  endfunction

endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync,
  output logic q_first
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d_async;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d_async};
      end
    end
  endgenerate

  assign q_first = chain[0];
  assign q_sync  = chain[STAGES-1];
endmodule

// File: rtl/btn_history.sv
module btn_history #(
  parameter int HIST_LEN = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sample,
  output logic [HIST_LEN-1:0] hist
);
  always_ff @(posedge clk) begin
    if (rst) hist <= '0;
    else     hist <= {hist[HIST_LEN-2:0], sample};
  end
endmodule

// File: rtl/btn_pattern_match.sv
module btn_pattern_match
  import btn_pulser_pkg::*;
#(
  parameter int HIST_LEN = 16,
  parameter int LOW_LEN  = 2
) (
  input  logic [HIST_LEN-1:0] hist,
  output logic                hit
);
  localparam logic [MAX_HIST-1:0] FULL_PAT = settle_pattern(HIST_LEN, LOW_LEN);
  localparam logic [HIST_LEN-1:0] PAT      = FULL_PAT[HIST_LEN-1:0];

  assign hit = (hist == PAT);
endmodule

// File: rtl/btn_press_pulser.sv
module btn_press_pulser #(
  parameter int SYNC_STAGES = 2,
  parameter int HIST_LEN    = 16,
  parameter int LOW_LEN     = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_raw,
  output logic press_pulse
);
  logic                sync_first;
  logic                sync_level;
  logic [HIST_LEN-1:0] history;
  logic                shape_hit;
  logic                pulse_q;

  btn_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (btn_raw),
    .q_sync  (sync_level),
    .q_first (sync_first)
  );

  btn_history #(.HIST_LEN(HIST_LEN)) u_hist (
    .clk    (clk),
    .rst    (rst),
    .sample (sync_level),
    .hist   (history)
  );

  btn_pattern_match #(.HIST_LEN(HIST_LEN), .LOW_LEN(LOW_LEN)) u_match (
    .hist (history),
    .hit  (shape_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) pulse_q <= 1'b0;
    else     pulse_q <= shape_hit;
  end

  assign press_pulse = pulse_q;
endmodule

// File: rtl/btn_press_pulser_chk.sv
module btn_press_pulser_chk
  import btn_pulser_pkg::*;
#(
  parameter int HIST_LEN = 16,
  parameter int LOW_LEN  = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                btn_raw,
  input logic                sync_first,
  input logic                sync_level,
  input logic [HIST_LEN-1:0] history,
  input logic                press_pulse
);
  localparam logic [MAX_HIST-1:0] FULL_PAT = settle_pattern(HIST_LEN, LOW_LEN);
  localparam logic [HIST_LEN-1:0] PAT      = FULL_PAT[HIST_LEN-1:0];

  a_r1_first_stage: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> sync_first == $past(btn_raw));

  a_r1_second_stage: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> sync_level == $past(sync_first));

  a_r9_shift_in_lsb: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> history == {$past(history[HIST_LEN-2:0]), $past(sync_level)});

  a_r3_pattern_before_pulse: assert property (@(posedge clk) disable iff (rst)
    press_pulse |-> $past(history) == PAT);

  a_r4_one_cycle: assert property (@(posedge clk) disable iff (rst)
    press_pulse |=> !press_pulse);

  a_r2_cleared_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (!press_pulse && history == '0 && !sync_level));
endmodule

bind btn_press_pulser btn_press_pulser_chk #(.HIST_LEN(HIST_LEN), .LOW_LEN(LOW_LEN)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .btn_raw     (btn_raw),
  .sync_first  (sync_first),
  .sync_level  (sync_level),
  .history     (history),
  .press_pulse (press_pulse)
);

// File: tb/test_btn_press_pulser.sv
`timescale 1ns/1ps
module test_btn_press_pulser;
  localparam int LAT = 2 + 14 + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn_raw = 1'b0;
  logic press_pulse;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int expq[$];
  bit done = 1'b0;

  btn_press_pulser i_btn_press_pulser (
    .clk         (clk),
    .rst         (rst),
    .btn_raw     (btn_raw),
    .press_pulse (press_pulse)
  );

  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: every observed pulse must match the front of the expectation queue.
  always @(negedge clk) begin
    if (!rst && press_pulse) begin
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL R3/R4/R5/R6/R7/R8: pulse at cycle %0d, expected none", cyc);
      end else if (expq[0] != cyc) begin
        errors++;
        $display("FAIL R3/R4: pulse at cycle %0d, expected cycle %0d", cyc, expq[0]);
        if (expq[0] < cyc) void'(expq.pop_front());
      end else begin
        void'(expq.pop_front());
      end
    end
  end

  // Driver: hold a raw level for n samples; optionally predict a pulse.
  task automatic drive(input logic v, input int n, input bit predict);
    @(negedge clk);
    btn_raw = v;
    if (predict) expq.push_back(cyc + LAT);
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic drained(input string req);
    checks++;
    if (expq.size() != 0) begin
      errors++;
      $display("FAIL %s: %0d predicted pulse(s) missing, actual none, expected cycle %0d",
               req, expq.size(), expq[0]);
      expq.delete();
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung, expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R2: output low while held in reset, with the button high
    btn_raw = 1'b1;
    repeat (4) begin
      @(negedge clk);
      checks++;
      if (press_pulse !== 1'b0) begin
        errors++;
        $display("FAIL R2: pulse during reset actual %b expected 0", press_pulse);
      end
    end
    btn_raw = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    drive(1'b0, 20, 1'b0);

    // R1, R3, R9: clean press, latency of 2 + 14 + 1; R5: held high for long
    drive(1'b1, 80, 1'b1);
    drained("R3");
    drive(1'b0, 10, 1'b0);
    drained("R5");

    // R7: 13-sample glitch gives nothing
    drive(1'b1, 13, 1'b0);
    drive(1'b0, 30, 1'b0);
    drained("R7");

    // R7: exactly 14 samples gives one pulse
    drive(1'b1, 14, 1'b1);
    drive(1'b0, 30, 1'b0);
    drained("R7");

    // R6: bouncing press, only the final settled run counts
    drive(1'b1, 3, 1'b0);
    drive(1'b0, 2, 1'b0);
    drive(1'b1, 5, 1'b0);
    drive(1'b0, 3, 1'b0);
    drive(1'b1, 1, 1'b0);
    drive(1'b0, 2, 1'b0);
    drive(1'b1, 40, 1'b1);
    drive(1'b0, 4, 1'b0);
    drive(1'b1, 2, 1'b0);
    drive(1'b0, 20, 1'b0);
    drained("R6");

    // R8: one low sample before a long high run gives nothing
    drive(1'b1, 30, 1'b1);
    drive(1'b0, 1, 1'b0);
    drive(1'b1, 40, 1'b0);
    drained("R8");

    // R8 boundary: two lows suffice
    drive(1'b0, 2, 1'b0);
    drive(1'b1, 40, 1'b1);
    drained("R8");
    drive(1'b0, 20, 1'b0);

    // R2: reset part-way through a press restarts the fill from zeros
    drive(1'b1, 6, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    checks++;
    if (press_pulse !== 1'b0) begin
      errors++;
      $display("FAIL R2: pulse in reset actual %b expected 0", press_pulse);
    end
    @(negedge clk);
    rst = 1'b0;
    expq.push_back(cyc + LAT);
    repeat (40) @(negedge clk);
    drained("R2");
    drive(1'b0, 10, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule